// File: doc/BRIEF.md
# Split Instruction/Data Cache Request Dispatcher

This block sits at the head of the processor request queue of a core that has separate instruction and data L1 caches. For each pending request it chooses the one controller event that the request produces, and the line address that event acts on. The inputs are the request kind and line address. Each cache also supplies three inputs: a tag-present flag, a free-way flag for the indexed set, and the victim address its probe picked.

Before the request proceeds, a line that sits in the cache the request does not use must leave that cache. An instruction fetch whose line is held by the data cache therefore becomes an eviction of that line. A load, store or atomic whose line is held by the instruction cache is treated the same way. Otherwise the request becomes its own event when the target cache holds the line or has room for it. When the target set is full, the request becomes an eviction of the victim line. Atomics are handled as stores.

The decision is combinational. The resulting event is held in an output register with a valid/ready handshake, so the request is consumed only when the register can take it. Two error flags mark an illegal request kind and a line reported present in both caches at once.

Top module: `split_cache_dispatch`

## Requirements
- R1: An instruction fetch (kind 1) whose line is present in the data cache produces the eviction event (code 3) on the request address.
- R2: A load (kind 0), store (kind 2) or atomic (kind 3) whose line is present in the instruction cache produces the eviction event (code 3) on the request address.
- R3: When the other cache does not hold the line and the target cache (instruction cache for kind 1, data cache otherwise) reports the tag present, the event for the request kind is produced on the request address.
- R4: When neither cache holds the line and the target set has a free way, the event for the request kind is produced on the request address.
- R5: When neither cache holds the line and the target set has no free way, the eviction event (code 3) is produced on the victim address of the target cache. The other cache's victim is never used.
- R6: Kind 0 maps to event code 0 (load), kind 1 to code 1 (instruction fetch), and kinds 2 and 3 both map to code 2 (store). Kinds 4 to 7 are illegal: kind_err is high while such a request is at the head, the request is consumed, and no event is produced.
- R7: dual_hit is high whenever a valid request has both tag-present flags set. The decision then follows the wrong-cache rule of R1 and R2.
- R8: An accepted request shows its event on evt_valid at the first clock edge after acceptance. While evt_valid is high and evt_ready is low, the event code and address hold still and req_ready is low. With evt_ready high, a request can be accepted on every cycle. After reset, evt_valid is low and req_ready is high.
- R9: The wrong-cache check takes precedence over the target cache's free-way and victim inputs. A fetch hitting the data cache evicts the request line even when the instruction set is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is waiting at the head of the queue |
| req_ready | output | 1 | The request is consumed at this clock edge |
| req_kind | input | KIND_W | Request kind: 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr | input | ADDR_W | Line address of the request |
| icache_hit | input | 1 | Instruction cache holds the line |
| icache_room | input | 1 | Instruction cache set has a free way |
| icache_victim | input | ADDR_W | Victim line chosen by the instruction cache |
| dcache_hit | input | 1 | Data cache holds the line |
| dcache_room | input | 1 | Data cache set has a free way |
| dcache_victim | input | ADDR_W | Victim line chosen by the data cache |
| evt_valid | output | 1 | An event is offered to the controller |
| evt_ready | input | 1 | The controller takes the event |
| evt_code | output | 2 | 0 load, 1 fetch, 2 store, 3 eviction |
| evt_addr | output | ADDR_W | Line address the event acts on |
| kind_err | output | 1 | The request at the head has an illegal kind |
| dual_hit | output | 1 | The request line is present in both caches |

## Verification
The bench aims at cases where choosing the wrong cache gives a plausible but wrong answer. A design that swapped the target and other caches would evict on an ordinary hit. One that took the victim from the wrong cache would evict an unrelated line. One that checked the free way before the wrong-cache hit would leave a fetch's line in the data cache and evict a victim instead. The bench sends atomics and illegal kinds, and a design that mapped atomics to loads or let an illegal kind through would report a wrong or extra event. Random backpressure on evt_ready catches an output that changes or drops an event while stalled.

// File: rtl/split_cache_dispatch_pkg.sv
package split_cache_dispatch_pkg;

   typedef enum logic [1:0] {
      EV_LOAD  = 2'd0,
      EV_FETCH = 2'd1,
      EV_STORE = 2'd2,
      EV_EVICT = 2'd3
   } evt_e;

   localparam int EVT_W = 2;

   localparam int K_LOAD   = 0;
   localparam int K_FETCH  = 1;
   localparam int K_STORE  = 2;
   localparam int K_ATOMIC = 3;

endpackage

// File: rtl/scd_kind_map.sv
module scd_kind_map
   import split_cache_dispatch_pkg::*;
#(
   parameter int KIND_W = 3
) (
   input  logic [KIND_W-1:0] kind,
   output evt_e              base_evt,
   output logic              is_fetch,
   output logic              legal
);

   always_comb begin
      base_evt = EV_LOAD;
      is_fetch = 1'b0;
      legal    = 1'b1;
      if (kind == KIND_W'(K_LOAD)) begin
         base_evt = EV_LOAD;
      end else if (kind == KIND_W'(K_FETCH)) begin
         base_evt = EV_FETCH;
         is_fetch = 1'b1;
      end else if (kind == KIND_W'(K_STORE) || kind == KIND_W'(K_ATOMIC)) begin
         base_evt = EV_STORE;
      end else begin
         legal = 1'b0;
      end
   end

endmodule

// File: rtl/scd_route.sv
module scd_route
   import split_cache_dispatch_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              is_fetch,
   input  evt_e              base_evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic              i_hit,
   input  logic              i_room,
   input  logic [ADDR_W-1:0] i_victim,
   input  logic              d_hit,
   input  logic              d_room,
   input  logic [ADDR_W-1:0] d_victim,
   output evt_e              evt,
   output logic [ADDR_W-1:0] evt_addr
);

   logic              own_hit;
   logic              own_room;
   logic              other_hit;
   logic [ADDR_W-1:0] own_victim;

   assign own_hit    = is_fetch ? i_hit    : d_hit;
   assign own_room   = is_fetch ? i_room   : d_room;
   assign own_victim = is_fetch ? i_victim : d_victim;
   assign other_hit  = is_fetch ? d_hit    : i_hit;

   always_comb begin
      if (other_hit) begin
         evt      = EV_EVICT;
         evt_addr = addr;
      end else if (own_hit || own_room) begin
         evt      = base_evt;
         evt_addr = addr;
      end else begin
         evt      = EV_EVICT;
         evt_addr = own_victim;
      end
   end

endmodule

// File: rtl/scd_out_stage.sv
module scd_out_stage #(
   parameter int W       = 34,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   generate
      if (OUT_REG) begin : g_reg
         logic         vld_q;
         logic [W-1:0] dat_q;

         assign in_ready  = !vld_q || out_ready;
         assign out_valid = vld_q;
         assign out_data  = dat_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else if (in_ready) begin
               vld_q <= in_valid;
               if (in_valid) dat_q <= in_data;
            end
         end
      end else begin : g_thru
         assign in_ready  = out_ready;
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end
   endgenerate

endmodule

// File: rtl/split_cache_dispatch.sv
module split_cache_dispatch
   import split_cache_dispatch_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int KIND_W  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [KIND_W-1:0] req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              icache_hit,
   input  logic              icache_room,
   input  logic [ADDR_W-1:0] icache_victim,
   input  logic              dcache_hit,
   input  logic              dcache_room,
   input  logic [ADDR_W-1:0] dcache_victim,
   output logic              evt_valid,
   input  logic              evt_ready,
   output logic [1:0]        evt_code,
   output logic [ADDR_W-1:0] evt_addr,
   output logic              kind_err,
   output logic              dual_hit
);

   localparam int PAY_W = EVT_W + ADDR_W;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("split_cache_dispatch: ADDR_W must be at least 1");
      end
      if (KIND_W < 2) begin : g_bad_kind
         $error("split_cache_dispatch: KIND_W must hold the four legal kinds");
      end
   endgenerate

   evt_e              base_evt;
   evt_e              sel_evt;
   logic              is_fetch;
   logic              legal;
   logic [ADDR_W-1:0] sel_addr;
   logic [PAY_W-1:0]  out_pay;

   scd_kind_map #(.KIND_W(KIND_W)) u_map (
      .kind     (req_kind),
      .base_evt (base_evt),
      .is_fetch (is_fetch),
      .legal    (legal)
   );

   scd_route #(.ADDR_W(ADDR_W)) u_route (
      .is_fetch (is_fetch),
      .base_evt (base_evt),
      .addr     (req_addr),
      .i_hit    (icache_hit),
      .i_room   (icache_room),
      .i_victim (icache_victim),
      .d_hit    (dcache_hit),
      .d_room   (dcache_room),
      .d_victim (dcache_victim),
      .evt      (sel_evt),
      .evt_addr (sel_addr)
   );

   scd_out_stage #(.W(PAY_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid && legal),
      .in_ready  (req_ready),
      .in_data   ({sel_evt, sel_addr}),
      .out_valid (evt_valid),
      .out_ready (evt_ready),
      .out_data  (out_pay)
   );

   assign evt_code = out_pay[PAY_W-1 -: EVT_W];
   assign evt_addr = out_pay[ADDR_W-1:0];
   assign kind_err = req_valid && !legal;
   assign dual_hit = req_valid && icache_hit && dcache_hit;

endmodule

// File: rtl/split_cache_dispatch_chk.sv
module split_cache_dispatch_chk
   import split_cache_dispatch_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int KIND_W  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [KIND_W-1:0] req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              icache_hit,
   input logic              icache_room,
   input logic [ADDR_W-1:0] icache_victim,
   input logic              dcache_hit,
   input logic              dcache_room,
   input logic [ADDR_W-1:0] dcache_victim,
   input logic              evt_valid,
   input logic              evt_ready,
   input logic [1:0]        evt_code,
   input logic [ADDR_W-1:0] evt_addr,
   input logic              kind_err,
   input logic              dual_hit
);

   logic take;
   logic is_data;
   logic illegal;

   assign take    = req_valid && req_ready;
   assign illegal = req_kind > KIND_W'(K_ATOMIC);
   assign is_data = !illegal && req_kind != KIND_W'(K_FETCH);

   AST_DUAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && icache_hit && dcache_hit) |-> dual_hit); // R7

   AST_KIND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && illegal) |-> kind_err); // R6

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_ready) |-> !req_ready); // R8

   generate
      if (OUT_REG) begin : g_reg_props
         AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && !evt_ready) |=>
               (evt_valid && $stable(evt_code) && $stable(evt_addr))); // R8

         AST_FETCH_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
            (take && req_kind == KIND_W'(K_FETCH) && dcache_hit) |=>
               (evt_valid && evt_code == 2'd3 && evt_addr == $past(req_addr))); // R1

         AST_DATA_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
            (take && is_data && icache_hit) |=>
               (evt_valid && evt_code == 2'd3 && evt_addr == $past(req_addr))); // R2

         AST_DATA_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
            (take && is_data && !icache_hit && !dcache_hit && !dcache_room) |=>
               (evt_valid && evt_code == 2'd3 && evt_addr == $past(dcache_victim))); // R5

         AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (take && illegal) |=> !evt_valid); // R6
      end
   endgenerate

endmodule

bind split_cache_dispatch split_cache_dispatch_chk #(
   .ADDR_W  (ADDR_W),
   .KIND_W  (KIND_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_kind      (req_kind),
   .req_addr      (req_addr),
   .icache_hit    (icache_hit),
   .icache_room   (icache_room),
   .icache_victim (icache_victim),
   .dcache_hit    (dcache_hit),
   .dcache_room   (dcache_room),
   .dcache_victim (dcache_victim),
   .evt_valid     (evt_valid),
   .evt_ready     (evt_ready),
   .evt_code      (evt_code),
   .evt_addr      (evt_addr),
   .kind_err      (kind_err),
   .dual_hit      (dual_hit)
);

// File: tb/split_cache_dispatch_test.sv
module split_cache_dispatch_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_kind = '0;
   logic [31:0] req_addr = '0;
   logic        icache_hit = 1'b0;
   logic        icache_room = 1'b0;
   logic [31:0] icache_victim = '0;
   logic        dcache_hit = 1'b0;
   logic        dcache_room = 1'b0;
   logic [31:0] dcache_victim = '0;
   logic        evt_valid;
   logic        evt_ready = 1'b1;
   logic [1:0]  evt_code;
   logic [31:0] evt_addr;
   logic        kind_err;
   logic        dual_hit;

   int checks = 0;
   int fails  = 0;
   int bp_mode = 0;
   logic [33:0] exp_q[$];
   string       tag_q[$];
   logic        stall_seen = 1'b0;
   logic [33:0] stall_val = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   split_cache_dispatch uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr),
      .icache_hit(icache_hit), .icache_room(icache_room), .icache_victim(icache_victim),
      .dcache_hit(dcache_hit), .dcache_room(dcache_room), .dcache_victim(dcache_victim),
      .evt_valid(evt_valid), .evt_ready(evt_ready),
      .evt_code(evt_code), .evt_addr(evt_addr),
      .kind_err(kind_err), .dual_hit(dual_hit)
   );

   task automatic check(input bit ok, input string req, input logic [33:0] got, input logic [33:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual code=%0d addr=%h, expected code=%0d addr=%h",
                  req, got[33:32], got[31:0], exp[33:32], exp[31:0]);
      end
   endtask

   function automatic logic [33:0] model(input logic [2:0] k, input logic [31:0] a,
         input logic ih, input logic ir, input logic [31:0] iv,
         input logic dh, input logic dr, input logic [31:0] dv);
      logic f;
      logic [1:0] base;
      f = (k == 3'd1);
      base = (k == 3'd0) ? 2'd0 : (f ? 2'd1 : 2'd2);
      if (f ? dh : ih) return {2'd3, a};
      if (f ? (ih || ir) : (dh || dr)) return {base, a};
      return {2'd3, f ? iv : dv};
   endfunction

   task automatic send(input logic [2:0] k, input logic [31:0] a,
         input logic ih, input logic ir, input logic [31:0] iv,
         input logic dh, input logic dr, input logic [31:0] dv, input string tag);
      bit legal;
      legal = (k <= 3'd3);
      @(negedge clk);
      req_kind = k; req_addr = a;
      icache_hit = ih; icache_room = ir; icache_victim = iv;
      dcache_hit = dh; dcache_room = dr; dcache_victim = dv;
      req_valid = 1'b1;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      check(kind_err == !legal, "R6 kind_err", {1'b0, kind_err, 32'h0}, {1'b0, !legal, 32'h0});
      check(dual_hit == (ih && dh), "R7 dual_hit", {1'b0, dual_hit, 32'h0}, {1'b0, ih && dh, 32'h0});
      if (legal) begin
         exp_q.push_back(model(k, a, ih, ir, iv, dh, dr, dv));
         tag_q.push_back(tag);
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   // backpressure driver
   always @(posedge clk) begin
      #2;
      evt_ready <= (bp_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_seen)
            check(evt_valid && {evt_code, evt_addr} == stall_val, "R8 hold while stalled",
                  {evt_code, evt_addr}, stall_val);
         stall_seen = evt_valid && !evt_ready;
         stall_val  = {evt_code, evt_addr};
         if (stall_seen)
            check(!req_ready, "R8 ready low while stalled", {1'b0, req_ready, 32'h0}, 34'h0);
         if (evt_valid && evt_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected event", {evt_code, evt_addr}, 34'h0);
            end else begin
               logic [33:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({evt_code, evt_addr} == e, t, {evt_code, evt_addr}, e);
            end
         end
      end
   end

   task automatic summary_and_end();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      summary_and_end();
   end

   task automatic drain();
      int n = 0;
      while (exp_q.size() != 0 && n < 1000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!evt_valid && req_ready, "R8 reset state",
            {evt_valid, req_ready, 32'h0}, {2'b01, 32'h0});

      // R1 and R9: fetch found in data cache while instruction set is full
      send(3'd1, 32'h1000, 1'b0, 1'b0, 32'hAAAA0000, 1'b1, 1'b0, 32'hBBBB0000, "R1 R9 fetch in dcache");
      // R2: data kinds found in instruction cache
      send(3'd0, 32'h2000, 1'b1, 1'b0, 32'hAAAA0001, 1'b0, 1'b0, 32'hBBBB0001, "R2 load in icache");
      send(3'd2, 32'h2040, 1'b1, 1'b1, 32'hAAAA0002, 1'b0, 1'b1, 32'hBBBB0002, "R2 store in icache");
      send(3'd3, 32'h2080, 1'b1, 1'b0, 32'hAAAA0003, 1'b0, 1'b0, 32'hBBBB0003, "R2 atomic in icache");
      // R3 hits in the target cache
      send(3'd0, 32'h3000, 1'b0, 1'b0, 32'hAAAA0004, 1'b1, 1'b0, 32'hBBBB0004, "R3 load hit");
      send(3'd1, 32'h3040, 1'b1, 1'b0, 32'hAAAA0005, 1'b0, 1'b0, 32'hBBBB0005, "R3 fetch hit");
      send(3'd2, 32'h3080, 1'b0, 1'b0, 32'hAAAA0006, 1'b1, 1'b0, 32'hBBBB0006, "R3 store hit");
      send(3'd3, 32'h30C0, 1'b0, 1'b0, 32'hAAAA0007, 1'b1, 1'b0, 32'hBBBB0007, "R6 atomic as store");
      // R4 misses with a free way
      send(3'd0, 32'h4000, 1'b0, 1'b0, 32'hAAAA0008, 1'b0, 1'b1, 32'hBBBB0008, "R4 load free way");
      send(3'd1, 32'h4040, 1'b0, 1'b1, 32'hAAAA0009, 1'b0, 1'b0, 32'hBBBB0009, "R4 fetch free way");
      // R5 misses with a full set
      send(3'd2, 32'h5000, 1'b0, 1'b1, 32'hAAAA000A, 1'b0, 1'b0, 32'hBBBB000A, "R5 store victim");
      send(3'd1, 32'h5040, 1'b0, 1'b0, 32'hAAAA000B, 1'b0, 1'b1, 32'hBBBB000B, "R5 fetch victim");
      // R6 illegal kinds
      send(3'd5, 32'h6000, 1'b0, 1'b1, 32'hAAAA000C, 1'b0, 1'b1, 32'hBBBB000C, "R6 illegal");
      send(3'd7, 32'h6040, 1'b1, 1'b1, 32'hAAAA000D, 1'b1, 1'b1, 32'hBBBB000D, "R6 illegal");
      // R7 both caches report the line
      send(3'd1, 32'h7000, 1'b1, 1'b1, 32'hAAAA000E, 1'b1, 1'b1, 32'hBBBB000E, "R7 dual fetch");
      send(3'd0, 32'h7040, 1'b1, 1'b1, 32'hAAAA000F, 1'b1, 1'b1, 32'hBBBB000F, "R7 dual load");
      drain();

      // R8 latency: event visible one edge after acceptance
      send(3'd0, 32'h8000, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "R8 latency");
      @(negedge clk);
      check(evt_valid && evt_code == 2'd0 && evt_addr == 32'h8000, "R8 one-cycle latency",
            {evt_code, evt_addr}, {2'd0, 32'h8000});
      drain();

      // random traffic under backpressure
      bp_mode = 1;
      for (int i = 0; i < 300; i++) begin
         send(3'($urandom % 6), $urandom, 1'($urandom), 1'($urandom), $urandom,
              1'($urandom), 1'($urandom), $urandom, "R3 R4 R5 random");
      end
      bp_mode = 0;
      drain();
      check(exp_q.size() == 0 && !evt_valid, "R6 no stray events",
            {evt_valid, 1'b0, 32'(exp_q.size())}, 34'h0);
      summary_and_end();
   end

endmodule